// File: doc/BRIEF.md
# Width-Overriding Packed Element ALU

This block computes one element of an integer vector operation whose source and destination element widths are chosen independently, each 8, 16, 32 or 64 bits. The two source operands arrive as 64-bit register images with elements packed little-endian. The block picks the indexed element out of each image at the source width and widens it, by sign or zero extension, to a precision where the arithmetic cannot overflow. It then adds, subtracts or multiplies. Saturation is optional and is decided on the exact result before the block narrows it to the destination width.

The narrowed value is written into a copy of the previous destination image at the same element index, at the destination width. Every other byte of that image is kept. A sequencer that steps an element counter from 0 up to the vector length minus one can feed the merged word back in as the next old destination word. This builds up a packed result register one element at a time. The result is registered and appears one cycle after the operands are presented.

Top module: `pw_elem_alu`

## Requirements
- R1: Width codes are 0=8, 1=16, 2=32 and 3=64 bits. Element k of a register image at width w occupies bits [k*w + w-1 : k*w], so element 0 sits in the least-significant bits.
- R2: The element index is taken modulo the number of elements that fit in 64 bits at the relevant width: 8, 4, 2 or 1. The source width decides this for extraction and the destination width for placement. Higher index bits are ignored.
- R3: Each source element is read at the source width. It is sign-extended when `is_signed` is 1 and zero-extended otherwise, and the arithmetic is exact with no intermediate wrap.
- R4: Opcode 0 computes a+b, 1 computes a-b, 2 computes a*b and 3 computes b-a, where a comes from `src_a` and b from `src_b`.
- R5: With `saturate` at 0, the destination element receives the low destination-width bits of the exact result.
- R6: With `saturate` at 1 and `is_signed` at 0, an exact result above 2^w-1 is written as 2^w-1 and a negative exact result is written as 0 (w is the destination width).
- R7: With `saturate` at 1 and `is_signed` at 1, the exact result is clamped to the range [-2^(w-1), 2^(w-1)-1] of the destination width.
- R8: Only the bytes of the indexed destination element are replaced. Every other byte of `out_word` equals the corresponding byte of `dst_old`.
- R9: `out_valid` is high exactly in the cycle after a cycle with `in_valid` high. `out_word` changes only after such a cycle and holds its value otherwise.
- R10: During and after an asynchronous active-low reset, `out_valid` and `out_word` are zero until the first accepted operation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Operands are present this cycle |
| op | input | 2 | Operation code (add, sub, mul, reverse sub) |
| is_signed | input | 1 | Signed interpretation of sources and saturation |
| saturate | input | 1 | Clamp instead of truncating |
| src_wsel | input | 2 | Source element width code |
| dst_wsel | input | 2 | Destination element width code |
| elem_idx | input | 3 | Element index |
| src_a | input | 64 | First source register image |
| src_b | input | 64 | Second source register image |
| dst_old | input | 64 | Previous destination register image |
| out_valid | output | 1 | Result word is fresh |
| out_word | output | 64 | Merged destination register image |

## Verification
The sweep covers every pairing of source and destination width. It exercises narrowing, where a design that used the destination width to read sources would pick the wrong bits, and widening, where missing sign extension would turn -128+-128 into +256. Saturation is driven past both limits, including unsigned subtraction that goes negative. A design that clamped the already truncated value would pass wrapped garbage, and one that clamped only at the top would give large positive values for underflow. Index values beyond the element count of the chosen width check that the index wraps rather than spilling into neighbouring bytes. Preloaded destination words check that untouched bytes survive.

// File: rtl/pwalu_pkg.sv
package pwalu_pkg;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_SUB  = 2'd1,
        OP_MUL  = 2'd2,
        OP_RSUB = 2'd3
    } alu_op_e;

    // Element width in bits for a 2-bit width code (8 << code).
    function automatic int unsigned wbits(input logic [1:0] code);
        return 32'd8 << code;
    endfunction

endpackage

// File: rtl/pwalu_extract.sv
module pwalu_extract #(
    parameter int REG_W = 64,
    parameter int IDX_W = 3,
    parameter int EXT_W = REG_W + 2
) (
    input  logic [REG_W-1:0] word,
    input  logic [1:0]       wcode,
    input  logic [IDX_W-1:0] idx,
    input  logic             sgn,
    output logic [EXT_W-1:0] val
);
    localparam int LANES = REG_W / 8;

    logic [IDX_W-1:0] slot;
    logic [REG_W-1:0] shifted;
    int unsigned      nbits;
    logic             fill;

    always_comb begin
        nbits   = pwalu_pkg::wbits(wcode);
        // wrap the index to the element count at this width
        slot    = idx & IDX_W'((LANES >> wcode) - 1);
        shifted = word >> (int'(slot) * int'(nbits));
        fill    = sgn & shifted[nbits-1];
        val     = {EXT_W{fill}};
        for (int b = 0; b < REG_W; b++) begin
            if (b < int'(nbits)) val[b] = shifted[b];
        end
    end
endmodule

// File: rtl/pwalu_arith.sv
module pwalu_arith #(
    parameter int EXT_W = 66,
    parameter int RES_W = 2 * EXT_W
) (
    input  logic [EXT_W-1:0]        a,
    input  logic [EXT_W-1:0]        b,
    input  pwalu_pkg::alu_op_e      op,
    output logic signed [RES_W-1:0] res
);
    logic signed [RES_W-1:0] ax;
    logic signed [RES_W-1:0] bx;

    assign ax = $signed({{(RES_W-EXT_W){a[EXT_W-1]}}, a});
    assign bx = $signed({{(RES_W-EXT_W){b[EXT_W-1]}}, b});

    always_comb begin
        case (op)
            pwalu_pkg::OP_ADD:  res = ax + bx;
            pwalu_pkg::OP_SUB:  res = ax - bx;
            pwalu_pkg::OP_MUL:  res = ax * bx;
            default:            res = bx - ax;
        endcase
    end
endmodule

// File: rtl/pwalu_narrow.sv
module pwalu_narrow #(
    parameter int REG_W = 64,
    parameter int RES_W = 132
) (
    input  logic signed [RES_W-1:0] res,
    input  logic [1:0]              wcode,
    input  logic                    sat,
    input  logic                    sgn,
    output logic [REG_W-1:0]        val
);
    localparam logic signed [RES_W-1:0] ONE = 1;

    int unsigned             nbits;
    logic signed [RES_W-1:0] umax;
    logic signed [RES_W-1:0] smax;
    logic signed [RES_W-1:0] smin;
    logic signed [RES_W-1:0] clip;

    always_comb begin
        nbits = pwalu_pkg::wbits(wcode);
        umax  = (ONE <<< nbits) - ONE;
        smax  = (ONE <<< (nbits - 1)) - ONE;
        smin  = -(ONE <<< (nbits - 1));
        clip  = res;
        if (sat) begin
            if (sgn) begin
                if (res > smax)      clip = smax;
                else if (res < smin) clip = smin;
            end else begin
                if (res > umax)      clip = umax;
                else if (res < 0)    clip = '0;
            end
        end
        val = '0;
        for (int b = 0; b < REG_W; b++) begin
            if (b < int'(nbits)) val[b] = clip[b];
        end
    end
endmodule

// File: rtl/pwalu_merge.sv
module pwalu_merge #(
    parameter int REG_W = 64,
    parameter int IDX_W = 3,
    parameter int LANES = REG_W / 8
) (
    input  logic [REG_W-1:0] old_word,
    input  logic [REG_W-1:0] val,
    input  logic [1:0]       wcode,
    input  logic [IDX_W-1:0] idx,
    output logic [REG_W-1:0] new_word,
    output logic [LANES-1:0] lane_mask
);
    logic [IDX_W-1:0] slot;
    logic [REG_W-1:0] placed;

    always_comb begin
        slot   = idx & IDX_W'((LANES >> wcode) - 1);
        placed = val << (int'(slot) * int'(pwalu_pkg::wbits(wcode)));
    end

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_mask[g] = (IDX_W'(g >> wcode) == slot);
        assign new_word[g*8 +: 8] = lane_mask[g] ? placed[g*8 +: 8]
                                                 : old_word[g*8 +: 8];
    end
endmodule

// File: rtl/pw_elem_alu.sv
module pw_elem_alu #(
    parameter int REG_W = 64,
    parameter int IDX_W = $clog2(REG_W / 8)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [1:0]       op,
    input  logic             is_signed,
    input  logic             saturate,
    input  logic [1:0]       src_wsel,
    input  logic [1:0]       dst_wsel,
    input  logic [IDX_W-1:0] elem_idx,
    input  logic [REG_W-1:0] src_a,
    input  logic [REG_W-1:0] src_b,
    input  logic [REG_W-1:0] dst_old,
    output logic             out_valid,
    output logic [REG_W-1:0] out_word
);
    localparam int EXT_W = REG_W + 2;
    localparam int RES_W = 2 * EXT_W;
    localparam int LANES = REG_W / 8;

    typedef struct packed {
        logic             vld;
        logic [REG_W-1:0] word;
    } st_t;

    st_t st_d, st_q;

    logic [EXT_W-1:0]        opnd_a;
    logic [EXT_W-1:0]        opnd_b;
    logic signed [RES_W-1:0] arith_res;
    logic [REG_W-1:0]        narrow_val;
    logic [REG_W-1:0]        merged;
    logic [LANES-1:0]        lane_mask;

    pwalu_extract #(.REG_W(REG_W), .IDX_W(IDX_W), .EXT_W(EXT_W)) u_ext_a (
        .word(src_a), .wcode(src_wsel), .idx(elem_idx), .sgn(is_signed), .val(opnd_a)
    );
    pwalu_extract #(.REG_W(REG_W), .IDX_W(IDX_W), .EXT_W(EXT_W)) u_ext_b (
        .word(src_b), .wcode(src_wsel), .idx(elem_idx), .sgn(is_signed), .val(opnd_b)
    );
    pwalu_arith #(.EXT_W(EXT_W), .RES_W(RES_W)) u_arith (
        .a(opnd_a), .b(opnd_b), .op(pwalu_pkg::alu_op_e'(op)), .res(arith_res)
    );
    pwalu_narrow #(.REG_W(REG_W), .RES_W(RES_W)) u_narrow (
        .res(arith_res), .wcode(dst_wsel), .sat(saturate), .sgn(is_signed), .val(narrow_val)
    );
    pwalu_merge #(.REG_W(REG_W), .IDX_W(IDX_W), .LANES(LANES)) u_merge (
        .old_word(dst_old), .val(narrow_val), .wcode(dst_wsel), .idx(elem_idx),
        .new_word(merged), .lane_mask(lane_mask)
    );

    always_comb begin
        st_d     = st_q;
        st_d.vld = in_valid;
        if (in_valid) st_d.word = merged;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign out_valid = st_q.vld;
    assign out_word  = st_q.word;

    // ---------------- assertions ----------------
    logic [REG_W-1:0] keep_bits;
    logic [REG_W-1:0] dst_ones;

    for (genvar g = 0; g < LANES; g++) begin : g_keep
        assign keep_bits[g*8 +: 8] = {8{~lane_mask[g]}};
    end

    always_comb begin
        dst_ones = '0;
        for (int b = 0; b < REG_W; b++) begin
            if (b < int'(pwalu_pkg::wbits(dst_wsel))) dst_ones[b] = 1'b1;
        end
    end

    p_valid_latency_r9: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    p_idle_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> (!out_valid && $stable(out_word)));

    p_bytes_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> ((out_word & $past(keep_bits)) == ($past(dst_old) & $past(keep_bits))));

    p_usat_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && saturate && !is_signed &&
         (arith_res > $signed({{(RES_W-REG_W){1'b0}}, dst_ones}))) |-> (narrow_val == dst_ones));

    p_ssat_sign_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && saturate && is_signed && (arith_res < 0))
        |-> narrow_val[pwalu_pkg::wbits(dst_wsel) - 1]);
endmodule

// File: tb/pw_elem_alu_bench.sv
`timescale 1ns/1ps
module pw_elem_alu_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [1:0]  op = '0;
    logic        is_signed = 1'b0;
    logic        saturate = 1'b0;
    logic [1:0]  src_wsel = '0;
    logic [1:0]  dst_wsel = '0;
    logic [2:0]  elem_idx = '0;
    logic [63:0] src_a = '0;
    logic [63:0] src_b = '0;
    logic [63:0] dst_old = '0;
    logic        out_valid;
    logic [63:0] out_word;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pw_elem_alu u_pw_elem_alu (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op),
        .is_signed(is_signed), .saturate(saturate), .src_wsel(src_wsel),
        .dst_wsel(dst_wsel), .elem_idx(elem_idx), .src_a(src_a), .src_b(src_b),
        .dst_old(dst_old), .out_valid(out_valid), .out_word(out_word)
    );

    function automatic logic signed [131:0] m_elem(logic [63:0] w, int wid, int idx, bit sg);
        int k = idx % (64 / wid);
        logic signed [131:0] v = '0;
        for (int b = 0; b < wid; b++) v[b] = w[k*wid + b];
        if (sg && w[k*wid + wid - 1]) v = v - (132'sd1 <<< wid);
        return v;
    endfunction

    function automatic logic [63:0] m_expect(logic [63:0] a, logic [63:0] b, logic [63:0] old,
                                             int code, int sw, int dw, int idx, bit sg, bit st);
        logic signed [131:0] x = m_elem(a, sw, idx, sg);
        logic signed [131:0] y = m_elem(b, sw, idx, sg);
        logic signed [131:0] r;
        logic signed [131:0] hi;
        logic signed [131:0] lo;
        logic [63:0] e = old;
        int k = idx % (64 / dw);
        case (code)
            0: r = x + y;
            1: r = x - y;
            2: r = x * y;
            default: r = y - x;
        endcase
        if (st) begin
            if (sg) begin
                hi = (132'sd1 <<< (dw-1)) - 132'sd1;
                lo = -(132'sd1 <<< (dw-1));
            end else begin
                hi = (132'sd1 <<< dw) - 132'sd1;
                lo = '0;
            end
            if (r > hi) r = hi;
            if (r < lo) r = lo;
        end
        for (int bt = 0; bt < dw; bt++) e[k*dw + bt] = r[bt];
        return e;
    endfunction

    task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic apply(int code, int sw, int dw, int idx, bit sg, bit st,
                         logic [63:0] a, logic [63:0] b, logic [63:0] old);
        @(negedge clk);
        op = 2'(code); src_wsel = 2'(sw); dst_wsel = 2'(dw); elem_idx = 3'(idx);
        is_signed = sg; saturate = st; src_a = a; src_b = b; dst_old = old;
        in_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
    endtask

    function automatic string sat_tag(bit sg, bit st);
        if (!st) return "R5";
        return sg ? "R7" : "R6";
    endfunction

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            $display("FAIL R9 watchdog actual=hung expected=done");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [63:0] a, b, old, hold;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check("R10 reset valid", {63'd0, out_valid}, 64'd0);
        check("R10 reset word", out_word, 64'd0);
        rst_n = 1'b1;

        // R1: 16-bit element 2 at bits 47:32
        apply(0, 1, 1, 2, 0, 0, 64'h0000_0003_0000_0000, 64'h0000_0004_0000_0000, '1);
        check("R1 le packing", out_word, 64'hFFFF_0007_FFFF_FFFF);
        check("R9 valid after accept", {63'd0, out_valid}, 64'd1);
        // R2: index 5 at 32-bit wraps to element 1
        apply(2, 2, 2, 5, 0, 0, 64'h0000_0002_0000_0000, 64'h0000_0003_0000_0000, '0);
        check("R2 index wrap", out_word, 64'h0000_0006_0000_0000);
        // R3: 8-bit sources into 16-bit destination, signed then unsigned
        apply(0, 0, 1, 0, 1, 0, 64'h80, 64'h80, '0);
        check("R3 sign extend", out_word, 64'h0000_0000_0000_FF00);
        apply(0, 0, 1, 0, 0, 0, 64'h80, 64'h80, '0);
        check("R3 zero extend", out_word, 64'h0000_0000_0000_0100);
        // R4: reverse subtract
        apply(3, 0, 0, 0, 0, 0, 64'h01, 64'h05, '0);
        check("R4 reverse sub", out_word, 64'h04);
        // R6: unsigned underflow clamps to zero
        apply(1, 0, 0, 1, 0, 1, 64'h0100, 64'h0500, 64'hFFFF);
        check("R6 unsigned floor", out_word, 64'h00FF);
        // R7: signed 16-bit overflow clamps to max
        apply(0, 1, 1, 0, 1, 1, 64'h7000, 64'h7000, '0);
        check("R7 signed ceiling", out_word, 64'h7FFF);
        // R8: byte 3 replaced, others kept
        apply(0, 0, 0, 3, 0, 0, 64'h0100_0000, 64'h0200_0000, {8{8'hA5}});
        check("R8 neighbours kept", out_word, 64'hA5A5_A5A5_03A5_A5A5);
        // R9: idle cycle drops valid and holds the word
        hold = out_word;
        in_valid = 1'b0;
        @(posedge clk);
        @(negedge clk);
        check("R9 idle valid", {63'd0, out_valid}, 64'd0);
        check("R9 idle hold", out_word, hold);

        // near-exhaustive sweep over control space
        for (int p = 0; p < 3; p++) begin
            for (int sw = 0; sw < 4; sw++) begin
                for (int dw = 0; dw < 4; dw++) begin
                    for (int code = 0; code < 4; code++) begin
                        for (int sg = 0; sg < 2; sg++) begin
                            for (int st = 0; st < 2; st++) begin
                                for (int ix = 0; ix < 8; ix++) begin
                                    if (p == 1) begin
                                        a = 64'h7FFF_8000_FF80_7F01;
                                        b = 64'h8000_7FFF_80FF_017F;
                                    end else begin
                                        a = {$urandom, $urandom};
                                        b = {$urandom, $urandom};
                                    end
                                    old = {$urandom, $urandom};
                                    apply(code, sw, dw, ix, sg[0], st[0], a, b, old);
                                    check(sat_tag(sg[0], st[0]), out_word,
                                          m_expect(a, b, old, code, 8 << sw, 8 << dw,
                                                   ix, sg[0], st[0]));
                                end
                            end
                        end
                    end
                end
            end
        end
        in_valid = 1'b0;
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule